// File: doc/BRIEF.md
# EEPROM Page Write Buffer

This block sits between the serial command engine of a small EEPROM and its byte-wide storage array. When a write command has received its address, the command engine pulses a start strobe with the 8-bit target address. The block keeps the upper address bits as the page number. The low bits become a byte pointer into a 16-entry staging buffer. Each data byte that follows lands at the pointer, and the pointer then advances. Past the last slot of the page it returns to slot zero, so later bytes replace earlier ones. A per-slot valid mask records which slots actually received data.

Nothing reaches the array until the host deselects. The block commits only if the deselect comes exactly on a byte boundary and at least one byte was received. On a commit it first asks the protection unit for permission, presenting the page number. If permission is granted, it sweeps the slots in ascending order and issues one array write per cycle for every valid slot whose address is not block-protected. It then holds busy for a fixed programming time. While busy, new start strobes are ignored.

Top module: `pgwr_buf`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `cmt_req_o` are all low.
- R2: The byte accepted with the k-th data strobe after a start is written to the address whose upper 4 bits are the start address's upper bits and whose lower 4 bits are (start low nibble + k) mod 16. The write data is that byte.
- R3: When the slot pointer passes offset 15, it continues at offset 0 of the same page. A byte arriving later for a slot replaces the earlier one, and only the last value is written.
- R4: Only slots that received a byte since the most recent accepted start are written. A new start while collecting discards everything gathered before it.
- R5: A deselect commits only when `bitcnt_i` (bits already received of the current byte, 0 meaning on a byte boundary) is 0. Any other value cancels the write: no request, no array write, no busy.
- R6: A deselect after a start with no data byte received makes no request and no array write.
- R7: A committing deselect raises `cmt_req_o` for exactly one cycle, in the cycle after the deselect, with `cmt_page_o` equal to the page. If `perm_ok_i` is low in that cycle, no array write follows and `busy_o` falls in the next cycle.
- R8: With protection level `prot_lvl_i` = 1, addresses 0xC0–0xFF are not written. With level 2, addresses 0x80–0xFF are not written. With level 3, no address is written. Level 0 protects nothing.
- R9: After a grant, array writes occur one per cycle in ascending offset order, within the 16 cycles that follow the request cycle.
- R10: `busy_o` is high from the request cycle through 16 sweep cycles plus `TWR_CYC` (default 64) hold cycles, 81 cycles in all. Start strobes, data strobes and deselects during busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse: write command opened |
| start_addr_i | input | 8 | Start address of the write |
| byte_vld_i | input | 1 | Pulse: a data byte is complete |
| byte_dat_i | input | 8 | Data byte |
| bitcnt_i | input | 3 | Bits received of the current byte when deselect occurs |
| desel_i | input | 1 | Pulse: chip select rose |
| prot_lvl_i | input | 2 | Block protection level |
| perm_ok_i | input | 1 | Protection unit grants the page commit |
| mem_we_o | output | 1 | Array byte write enable |
| mem_addr_o | output | 8 | Array byte address |
| mem_wdat_o | output | 8 | Array byte data |
| cmt_req_o | output | 1 | Commit request to the protection unit |
| cmt_page_o | output | 4 | Page number of the commit request |
| busy_o | output | 1 | Programming in progress |

## Verification
The assertions assume that a deselect pulse never coincides with a data strobe and that `perm_ok_i` and `prot_lvl_i` hold steady while a commit is being swept. Within those limits they check only how the request, busy and array-write outputs relate to one another. The stimulus respects these limits in the same way throughout. Every strobe is a single-cycle pulse driven just after a falling edge. The grant and protection level are set before each deselect and left unchanged until busy drops. Stray starts, strobes and deselects during busy are issued only in the one scenario that tests R10.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_PROG,
    SQ_HOLD
  } sq_state_e;

  // Block protection: decided from the top two address bits
  function automatic logic blk_locked(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'd0:    blk_locked = 1'b0;
      2'd1:    blk_locked = (top2 == 2'b11);
      2'd2:    blk_locked = top2[1];
      default: blk_locked = 1'b1;
    endcase
  endfunction

  // Slot pointer advance with wrap inside the page
  function automatic logic [7:0] slot_next(input logic [7:0] ofs, input int unsigned nslots);
    slot_next = (32'(ofs) + 1 == nslots) ? 8'd0 : ofs + 8'd1;
  endfunction

endpackage

// File: rtl/pgwr_collect.sv
module pgwr_collect #(
  parameter int OFS_W  = 4,
  parameter int PG_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   open_i,
  input  logic [PG_W+OFS_W-1:0]  open_addr_i,
  input  logic                   close_i,
  input  logic                   byte_vld_i,
  input  logic [DATA_W-1:0]      byte_dat_i,
  input  logic [OFS_W-1:0]       rd_ofs_i,
  output logic                   armed_o,
  output logic [PG_W-1:0]        page_o,
  output logic [(1<<OFS_W)-1:0]  vmask_o,
  output logic [DATA_W-1:0]      rd_dat_o
);
  import pgwr_pkg::*;

  localparam int NSLOT = 1 << OFS_W;

  logic [OFS_W-1:0]  ptr_q;
  logic              take_byte;
  logic [DATA_W-1:0] slot_q [NSLOT];

  assign take_byte = armed_o && byte_vld_i && !open_i && !close_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      ptr_q   <= '0;
      page_o  <= '0;
      vmask_o <= '0;
    end else if (open_i) begin
      armed_o <= 1'b1;
      ptr_q   <= open_addr_i[OFS_W-1:0];
      page_o  <= open_addr_i[PG_W+OFS_W-1:OFS_W];
      vmask_o <= '0;
    end else if (close_i) begin
      armed_o <= 1'b0;
    end else if (take_byte) begin
      vmask_o[ptr_q] <= 1'b1;
      ptr_q          <= OFS_W'(slot_next(8'(ptr_q), NSLOT));
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (take_byte && ptr_q == OFS_W'(g)) slot_q[g] <= byte_dat_i;
    end
  end

  assign rd_dat_o = slot_q[rd_ofs_i];

endmodule

// File: rtl/pgwr_sched.sv
module pgwr_sched #(
  parameter int OFS_W   = 4,
  parameter int PG_W    = 4,
  parameter int TWR_CYC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_i,
  input  logic                  grant_i,
  input  logic [1:0]            prot_lvl_i,
  input  logic [PG_W-1:0]       page_i,
  input  logic [(1<<OFS_W)-1:0] vmask_i,
  output logic                  req_o,
  output logic                  busy_o,
  output logic                  we_o,
  output logic [OFS_W-1:0]      ofs_o
);
  import pgwr_pkg::*;

  localparam int TMR_W = $clog2(TWR_CYC + 1);
  localparam logic [OFS_W-1:0] LAST_OFS = '1;

  sq_state_e  st_q;
  logic [TMR_W-1:0] tmr_q;
  logic       page_locked;

  assign page_locked = blk_locked(prot_lvl_i, page_i[PG_W-1:PG_W-2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ofs_o <= '0;
      tmr_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (commit_i) st_q <= SQ_REQ;
        SQ_REQ: begin
          ofs_o <= '0;
          st_q  <= grant_i ? SQ_PROG : SQ_IDLE;
        end
        SQ_PROG: begin
          ofs_o <= ofs_o + 1'b1;
          if (ofs_o == LAST_OFS) begin
            st_q  <= SQ_HOLD;
            tmr_q <= TMR_W'(TWR_CYC - 1);
          end
        end
        default: begin
          if (tmr_q == '0) st_q <= SQ_IDLE;
          else tmr_q <= tmr_q - 1'b1;
        end
      endcase
    end
  end

  assign req_o  = (st_q == SQ_REQ);
  assign busy_o = (st_q != SQ_IDLE);
  assign we_o   = (st_q == SQ_PROG) && vmask_i[ofs_o] && !page_locked;

endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TWR_CYC    = 64,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFS_W,
  localparam int BC_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_dat_i,
  input  logic [BC_W-1:0]   bitcnt_i,
  input  logic              desel_i,
  input  logic [1:0]        prot_lvl_i,
  input  logic              perm_ok_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdat_o,
  output logic              cmt_req_o,
  output logic [PG_W-1:0]   cmt_page_o,
  output logic              busy_o
);

  logic                  armed;
  logic [PG_W-1:0]       page;
  logic [PAGE_BYTES-1:0] vmask;
  logic [OFS_W-1:0]      sweep_ofs;

  // Named internal events
  logic open_ev, close_ev, commit_ev;
  assign open_ev   = start_i && !busy_o;
  assign close_ev  = desel_i && armed && !start_i;
  assign commit_ev = close_ev && (bitcnt_i == '0) && (|vmask);

  pgwr_collect #(.OFS_W(OFS_W), .PG_W(PG_W), .DATA_W(DATA_W)) collect_i (
    .clk(clk), .rst_n(rst_n),
    .open_i(open_ev), .open_addr_i(start_addr_i), .close_i(close_ev),
    .byte_vld_i(byte_vld_i), .byte_dat_i(byte_dat_i),
    .rd_ofs_i(sweep_ofs),
    .armed_o(armed), .page_o(page), .vmask_o(vmask), .rd_dat_o(mem_wdat_o)
  );

  pgwr_sched #(.OFS_W(OFS_W), .PG_W(PG_W), .TWR_CYC(TWR_CYC)) sched_i (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit_ev), .grant_i(perm_ok_i), .prot_lvl_i(prot_lvl_i),
    .page_i(page), .vmask_i(vmask),
    .req_o(cmt_req_o), .busy_o(busy_o), .we_o(mem_we_o), .ofs_o(sweep_ofs)
  );

  assign mem_addr_o = {page, sweep_ofs};
  assign cmt_page_o = page;

endmodule

// File: rtl/pgwr_buf_chk.sv
module pgwr_buf_chk #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 4,
  parameter int BC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desel_i,
  input logic [BC_W-1:0]   bitcnt_i,
  input logic              perm_ok_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              cmt_req_o,
  input logic              busy_o
);

  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req_o |=> !cmt_req_o);

  a_r5_req_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req_o |-> ($past(desel_i) && $past(bitcnt_i) == '0));

  a_r10_req_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req_o |-> busy_o);

  a_r7_denied_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_req_o && !perm_ok_i) |=> !busy_o);

  a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[OFS_W-1:0] > $past(mem_addr_o[OFS_W-1:0])));

  a_r2_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[ADDR_W-1:OFS_W] == $past(mem_addr_o[ADDR_W-1:OFS_W])));

  a_r10_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

endmodule

bind pgwr_buf pgwr_buf_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BC_W(BC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .desel_i(desel_i), .bitcnt_i(bitcnt_i),
  .perm_ok_i(perm_ok_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .cmt_req_o(cmt_req_o), .busy_o(busy_o)
);

// File: tb/pgwr_buf_tb.sv
module pgwr_buf_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_dat_i = '0;
  logic [2:0] bitcnt_i = '0;
  logic       desel_i = 1'b0;
  logic [1:0] prot_lvl_i = '0;
  logic       perm_ok_i = 1'b1;
  logic       mem_we_o;
  logic [7:0] mem_addr_o;
  logic [7:0] mem_wdat_o;
  logic       cmt_req_o;
  logic [3:0] cmt_page_o;
  logic       busy_o;

  always #2.5 clk = ~clk;

  pgwr_buf dut_i (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [15:0] exp_q[$];
  logic [7:0]  m_buf [16];
  logic [15:0] m_v;
  logic [3:0]  m_page, m_ptr;
  bit          m_armed = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit locked_addr(input logic [1:0] lvl, input logic [7:0] a);
    if (lvl == 2'd3) return 1;
    if (lvl == 2'd2) return a >= 8'h80;
    if (lvl == 2'd1) return a >= 8'hC0;
    return 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: pops expected array writes
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0)
        chk(0, "R5 unexpected write", int'({mem_addr_o, mem_wdat_o}), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({mem_addr_o, mem_wdat_o} == e, "R2 write addr/data",
            int'({mem_addr_o, mem_wdat_o}), int'(e));
      end
    end
  end

  task automatic do_start(input logic [7:0] a);
    @(negedge clk); start_i = 1; start_addr_i = a;
    @(negedge clk); start_i = 0;
    m_armed = 1; m_page = a[7:4]; m_ptr = a[3:0]; m_v = '0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_vld_i = 1; byte_dat_i = d;
    @(negedge clk); byte_vld_i = 0;
    if (m_armed) begin
      m_buf[m_ptr] = d; m_v[m_ptr] = 1; m_ptr = m_ptr + 4'd1;
    end
  endtask

  task automatic deselect(input logic [2:0] bc, input bit grant);
    bit commit;
    commit = m_armed && bc == 0 && m_v != 0;
    m_armed = 0;
    if (commit && grant)
      for (int o = 0; o < 16; o++)
        if (m_v[o] && !locked_addr(prot_lvl_i, {m_page, 4'(o)}))
          exp_q.push_back({m_page, 4'(o), m_buf[o]});
    @(negedge clk); desel_i = 1; bitcnt_i = bc; perm_ok_i = grant;
    @(negedge clk); desel_i = 0; bitcnt_i = 0;
    chk(cmt_req_o == commit, "R5 request on deselect", cmt_req_o, commit);
    chk(busy_o == commit, "R10 busy at request", busy_o, commit);
    if (commit) chk(cmt_page_o == m_page, "R7 request page", cmt_page_o, m_page);
    if (commit && grant) begin
      repeat (80) @(negedge clk);
      chk(busy_o == 1, "R10 busy last cycle", busy_o, 1);
      @(negedge clk);
      chk(busy_o == 0, "R10 busy released", busy_o, 0);
      chk(exp_q.size() == 0, "R9 all writes in sweep", exp_q.size(), 0);
    end else if (commit) begin
      @(negedge clk);
      chk(cmt_req_o == 0, "R7 request one cycle", cmt_req_o, 0);
      chk(busy_o == 0, "R7 denied frees busy", busy_o, 0);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
    chk(mem_we_o == 0, "R1 write after reset", mem_we_o, 0);
    chk(cmt_req_o == 0, "R1 request after reset", cmt_req_o, 0);
    rst_n = 1;

    // R2 single byte
    do_start(8'h35); send_byte(8'hA5); deselect(0, 1);
    // R2 short page run
    do_start(8'h40);
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
    deselect(0, 1);
    // R3 wrap and overwrite
    do_start(8'h2E);
    for (int i = 0; i < 18; i++) send_byte(8'h60 + 8'(i));
    deselect(0, 1);
    // R5 cancel off boundary
    do_start(8'h50); send_byte(8'h11); send_byte(8'h22); deselect(3, 1);
    do_start(8'h51); send_byte(8'h33); deselect(7, 1);
    // R6 no data
    do_start(8'h60); deselect(0, 1);
    // R4 restart discards
    do_start(8'h70); send_byte(8'hDE); send_byte(8'hAD);
    do_start(8'h7A); send_byte(8'hBE); deselect(0, 1);
    // R7 denied
    do_start(8'h10); send_byte(8'h77); deselect(0, 0);
    // R8 protection levels
    prot_lvl_i = 2'd1;
    do_start(8'hC3); send_byte(8'h01); deselect(0, 1);
    do_start(8'h83); send_byte(8'h02); deselect(0, 1);
    prot_lvl_i = 2'd2;
    do_start(8'h93); send_byte(8'h03); deselect(0, 1);
    do_start(8'h7F); send_byte(8'h04); deselect(0, 1);
    prot_lvl_i = 2'd3;
    do_start(8'h05); send_byte(8'h05); deselect(0, 1);
    prot_lvl_i = 2'd0;
    // R10 stimulus during busy is ignored
    do_start(8'h20); send_byte(8'h99);
    fork
      deselect(0, 1);
      begin
        repeat (10) @(negedge clk);
        start_i = 1; start_addr_i = 8'hE0;
        @(negedge clk); start_i = 0; byte_vld_i = 1; byte_dat_i = 8'h55;
        @(negedge clk); byte_vld_i = 0; desel_i = 1;
        @(negedge clk); desel_i = 0;
        chk(cmt_req_o == 0, "R10 deselect in busy ignored", cmt_req_o, 0);
      end
    join
    deselect(0, 1);
    repeat (20) @(negedge clk);
    chk(mem_we_o == 0 && busy_o == 0, "R10 start in busy ignored", busy_o, 0);
    finish_run();
  end

endmodule